// File: doc/BRIEF.md
# Loopback Entry Detector

This block sits beside a link training state machine on the receive side. It watches a stream of training ordered sets that have already been parsed and decides when the far end has asked this side to act as the loopback follower. The trigger is a run of back-to-back TS1 ordered sets that carry the loopback indication. Where that indication sits in the training-control field depends on the line encoding that is active. One instance can serve a single lane or a whole configured link.

Each ordered set arrives as a one-cycle strobe. With it come its kind, the low nibble of its training-control field and the current encoding mode. When the entry condition is met, the block raises a one-cycle request pulse and a sticky request level. The level stays set until the training logic asserts the exit input or reset is applied. Further qualifying sets add nothing while the level is held.

Top module: `loopback_entry_detect`

## Requirements
- R1: While reset is asserted and after it is released, `entryPulse` and `entryLevel` are both 0 until an entry condition occurs.
- R2: The clock edge that samples the REQ_CNT-th consecutive qualifying TS1 (default 2) sets `entryPulse` and `entryLevel`, so both read 1 in the following cycle. A single qualifying TS1 does not set them.
- R3: With `encMode` 0 (8b/10b) or 1 (128b/130b), a TS1 qualifies exactly when bit 2 of `trainCtl` is 1. The other bits of `trainCtl` are ignored.
- R4: With `encMode` 2 (1b/1b), a TS1 qualifies exactly when `trainCtl[3:0]` equals the parameter LB_CODE (default 4'h9). With `encMode` 3, no set qualifies.
- R5: `osKind` 1 marks a TS1, 2 a TS2, and 0 or 3 any other set. A valid set that is not a qualifying TS1 resets the consecutive count to zero. This applies to a TS2 carrying the loopback indication.
- R6: Cycles with `osValid` low leave the consecutive count unchanged.
- R7: Once `entryLevel` is 1, it stays 1 until `exitClr` is asserted. The count saturates, so further qualifying TS1 sets produce no new pulse.
- R8: `exitClr` clears `entryLevel` and the count on the next edge. It takes priority over a qualifying TS1 in the same cycle, and that TS1 is not counted.
- R9: `entryPulse` lasts one cycle and is high only in the cycle in which `entryLevel` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| osValid | input | 1 | An ordered set is presented this cycle |
| osKind | input | 2 | Ordered-set kind: 0 other, 1 TS1, 2 TS2, 3 other |
| trainCtl | input | 4 | Low nibble of the training-control field |
| encMode | input | 2 | Encoding: 0 8b/10b, 1 128b/130b, 2 1b/1b, 3 reserved |
| exitClr | input | 1 | Clears the request level and the count |
| entryPulse | output | 1 | One-cycle loopback-entry request |
| entryLevel | output | 1 | Sticky loopback-entry request |

## Verification
The exit input and a qualifying TS1 can arrive in the same cycle, and the exit must win. The bench drives them together twice. The first time, the collision falls on what would be the second qualifying set. The second time, it falls while the level is already held. In both cases the outputs must read 0 on the next cycle. A single qualifying TS1 sent afterwards must then raise no pulse, which shows the colliding set was not counted.

// File: rtl/lbdet_pkg.sv
package lbdet_pkg;

  typedef enum logic [1:0] {
    OS_OTHER = 2'd0,
    OS_TS1   = 2'd1,
    OS_TS2   = 2'd2,
    OS_RSVD  = 2'd3
  } os_kind_e;

  typedef enum logic [1:0] {
    ENC_8B10B   = 2'd0,
    ENC_128B130B = 2'd1,
    ENC_1B1B    = 2'd2,
    ENC_RSVD    = 2'd3
  } enc_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } cnt_strobe_t;

endpackage

// File: rtl/lbdet_datapath.sv
module lbdet_datapath
  import lbdet_pkg::*;
#(
  parameter int          REQ_CNT = 2,
  parameter logic [3:0]  LB_CODE = 4'h9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  osKind,
  input  logic [3:0]  trainCtl,
  input  logic [1:0]  encMode,
  input  cnt_strobe_t strobe,
  output logic        qualify,
  output logic        atLast
);

  localparam int CNT_W = $clog2(REQ_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(REQ_CNT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REQ_CNT - 1);

  logic             lbFlag;
  logic [CNT_W-1:0] runCnt;

  // loopback indication position depends on line encoding
  always_comb begin
    unique case (encMode)
      ENC_8B10B, ENC_128B130B: lbFlag = trainCtl[2];
      ENC_1B1B:                lbFlag = (trainCtl == LB_CODE);
      default:                 lbFlag = 1'b0;
    endcase
  end

  assign qualify = lbFlag && (osKind == OS_TS1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (strobe.clr) begin
      runCnt <= '0;
    end else if (strobe.inc && (runCnt != CNT_MAX)) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign atLast = (runCnt == CNT_LAST);

endmodule

// File: rtl/lbdet_ctrl.sv
module lbdet_ctrl
  import lbdet_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        osValid,
  input  logic        exitClr,
  input  logic        qualify,
  input  logic        atLast,
  output cnt_strobe_t strobe,
  output logic        entryPulse,
  output logic        entryLevel
);

  typedef enum logic {ST_WATCH = 1'b0, ST_HELD = 1'b1} ctl_state_e;

  ctl_state_e state, stateNext;
  logic       fire;
  logic       pulseQ;

  assign fire = osValid && qualify && atLast && !exitClr && (state == ST_WATCH);

  always_comb begin
    strobe.clr = exitClr || (osValid && !qualify);
    strobe.inc = !exitClr && osValid && qualify;
  end

  always_comb begin
    stateNext = state;
    if (exitClr) begin
      stateNext = ST_WATCH;
    end else if (fire) begin
      stateNext = ST_HELD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_WATCH;
      pulseQ <= 1'b0;
    end else begin
      state  <= stateNext;
      pulseQ <= fire;
    end
  end

  assign entryPulse = pulseQ;
  assign entryLevel = (state == ST_HELD);

endmodule

// File: rtl/loopback_entry_detect.sv
module loopback_entry_detect
  import lbdet_pkg::*;
#(
  parameter int         REQ_CNT = 2,
  parameter logic [3:0] LB_CODE = 4'h9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       osValid,
  input  logic [1:0] osKind,
  input  logic [3:0] trainCtl,
  input  logic [1:0] encMode,
  input  logic       exitClr,
  output logic       entryPulse,
  output logic       entryLevel
);

  cnt_strobe_t strobe;
  logic        qualify;
  logic        atLast;

  lbdet_datapath #(
    .REQ_CNT (REQ_CNT),
    .LB_CODE (LB_CODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .osKind   (osKind),
    .trainCtl (trainCtl),
    .encMode  (encMode),
    .strobe   (strobe),
    .qualify  (qualify),
    .atLast   (atLast)
  );

  lbdet_ctrl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .osValid    (osValid),
    .exitClr    (exitClr),
    .qualify    (qualify),
    .atLast     (atLast),
    .strobe     (strobe),
    .entryPulse (entryPulse),
    .entryLevel (entryLevel)
  );

endmodule

// File: rtl/lbdet_checker.sv
module lbdet_checker (
  input logic clk,
  input logic rstN,
  input logic osValid,
  input logic exitClr,
  input logic entryPulse,
  input logic entryLevel
);

  // R9
  pulse_with_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |-> entryLevel);

  // R9
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryPulse |=> !entryPulse);

  // R9
  level_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(entryLevel) |-> entryPulse);

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryLevel && !exitClr) |=> entryLevel);

  // R8
  exit_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    exitClr |=> (!entryLevel && !entryPulse));

  // R6
  pulse_needs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(entryPulse) |-> $past(osValid));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!entryPulse && !entryLevel));

endmodule

bind loopback_entry_detect lbdet_checker u_lbdet_chk (
  .clk        (clk),
  .rstN       (rstN),
  .osValid    (osValid),
  .exitClr    (exitClr),
  .entryPulse (entryPulse),
  .entryLevel (entryLevel)
);

// File: tb/tb_loopback_entry_detect.sv
module tb_loopback_entry_detect;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       osValid = 1'b0;
  logic [1:0] osKind = 2'd0;
  logic [3:0] trainCtl = 4'd0;
  logic [1:0] encMode = 2'd0;
  logic       exitClr = 1'b0;
  logic       entryPulse;
  logic       entryLevel;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  loopback_entry_detect dut (
    .clk        (clk),
    .rstN       (rstN),
    .osValid    (osValid),
    .osKind     (osKind),
    .trainCtl   (trainCtl),
    .encMode    (encMode),
    .exitClr    (exitClr),
    .entryPulse (entryPulse),
    .entryLevel (entryLevel)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chkOut(input string req, input logic expP, input logic expL);
    chk(req, "entryPulse", entryPulse, expP);
    chk(req, "entryLevel", entryLevel, expL);
  endtask

  // drive one ordered set, then sample shortly after the edge that takes it
  task automatic sendOs(input logic [1:0] kind, input logic [3:0] ctl,
                        input logic [1:0] enc, input logic clr);
    @(negedge clk);
    osValid  = 1'b1;
    osKind   = kind;
    trainCtl = ctl;
    encMode  = enc;
    exitClr  = clr;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    osValid = 1'b0;
    exitClr = 1'b0;
    @(posedge clk);
    #2;
  endtask

  task automatic doExit();
    @(negedge clk);
    osValid = 1'b0;
    exitClr = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic tReset();
    chkOut("R1", 1'b0, 1'b0);
    idle();
    chkOut("R1", 1'b0, 1'b0);
  endtask

  task automatic tBasic8b();
    doExit();
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R2", 1'b0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R2", 1'b1, 1'b1);
    idle();
    chkOut("R9", 1'b0, 1'b1);
  endtask

  task automatic tMode128();
    doExit();
    sendOs(2'd1, 4'hB, 2'd1, 1'b0);
    sendOs(2'd1, 4'hB, 2'd1, 1'b0);
    chkOut("R3", 1'b0, 1'b0);
    sendOs(2'd1, 4'hD, 2'd1, 1'b0);
    sendOs(2'd1, 4'h4, 2'd1, 1'b0);
    chkOut("R3", 1'b1, 1'b1);
    doExit();
    sendOs(2'd1, 4'h9, 2'd0, 1'b0);
    sendOs(2'd1, 4'h9, 2'd0, 1'b0);
    chkOut("R3", 1'b0, 1'b0);
  endtask

  task automatic tMode1b1b();
    doExit();
    sendOs(2'd1, 4'h4, 2'd2, 1'b0);
    sendOs(2'd1, 4'h4, 2'd2, 1'b0);
    chkOut("R4", 1'b0, 1'b0);
    sendOs(2'd1, 4'h9, 2'd2, 1'b0);
    sendOs(2'd1, 4'h9, 2'd2, 1'b0);
    chkOut("R4", 1'b1, 1'b1);
    doExit();
    sendOs(2'd1, 4'hF, 2'd3, 1'b0);
    sendOs(2'd1, 4'h9, 2'd3, 1'b0);
    sendOs(2'd1, 4'h4, 2'd3, 1'b0);
    chkOut("R4", 1'b0, 1'b0);
  endtask

  task automatic tIntervene();
    doExit();
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    sendOs(2'd2, 4'h4, 2'd0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R5", 1'b0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R5", 1'b1, 1'b1);
    doExit();
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    sendOs(2'd0, 4'h0, 2'd0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R5", 1'b0, 1'b0);
    sendOs(2'd3, 4'h4, 2'd0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R5", 1'b0, 1'b0);
  endtask

  task automatic tGap();
    doExit();
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    for (int i = 0; i < 3; i++) idle();
    chkOut("R6", 1'b0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R6", 1'b1, 1'b1);
  endtask

  task automatic tSaturate();
    doExit();
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R7", 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      sendOs(2'd1, 4'h4, 2'd0, 1'b0);
      chkOut("R7", 1'b0, 1'b1);
    end
    sendOs(2'd2, 4'h0, 2'd0, 1'b0);
    idle();
    chkOut("R7", 1'b0, 1'b1);
  endtask

  task automatic tExitCollide();
    doExit();
    chkOut("R8", 1'b0, 1'b0);
    // collision on the would-be second set
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b1);
    chkOut("R8", 1'b0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R8", 1'b0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R8", 1'b1, 1'b1);
    // collision while held
    sendOs(2'd1, 4'h4, 2'd0, 1'b1);
    chkOut("R8", 1'b0, 1'b0);
    sendOs(2'd1, 4'h4, 2'd0, 1'b0);
    chkOut("R8", 1'b0, 1'b0);
    idle();
  endtask

  initial begin
    #(8 * 100000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #3;
    chkOut("R1", 1'b0, 1'b0);
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    tReset();
    tBasic8b();
    tMode128();
    tMode1b1b();
    tIntervene();
    tGap();
    tSaturate();
    tExitCollide();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule